// File: doc/BRIEF.md
# RGMII Double-Data-Rate Adapter

This block sits between a MAC-side byte interface and a reduced-pin Ethernet PHY link. That link carries four data lines and one control line per direction, and both clock edges are used. On the transmit side it splits each byte into two nibbles, one for each half of the clock period. It folds the enable and error flags onto the single control line. It also forwards a clock that stays quiet until the selected speed agrees with the link speed. On the receive side it samples both halves of every period and rebuilds the byte together with the valid and error flags.

At 10 and 100 Mb/s the same link runs at a lower clock rate and carries one nibble per period. On transmit the nibble is repeated in both halves. On receive the adapter collects pairs of nibbles, low nibble first, into bytes and marks each complete byte with a strobe. Both directions share `clk_i` in this model. The capture and launch stages use flops on both clock edges and have no delay elements.

Top module: `rgmii_ddr_adapter`

## Requirements
- R1: At 1000 Mb/s (`speed_i[1]`=1), the low nibble of the byte sampled on a rising edge of `clk_i` is on `rgmii_txd_o` while the clock is high, and the high nibble is on it during the following low phase.
- R2: `rgmii_txctl_o` shows the sampled enable while the clock is high and enable XOR error while the clock is low. A good frame is therefore high in both phases, idle is low in both, and an errored frame is high then low.
- R3: At 10/100 Mb/s (`speed_i` 2'b00 = 10, 2'b01 = 100), `tx_data_i[3:0]` is on `rgmii_txd_o` in both phases, and `tx_data_i[7:4]` has no effect.
- R4: `rgmii_txc_o` stays low while `speed_i` differs from `link_speed_i`. While the two agree, it follows `clk_i`. The gating changes only on a falling edge.
- R5: At 1000 Mb/s, the byte {falling-edge nibble, rising-edge nibble} captured in one period appears on `rx_data_o` two rising edges after its rising-edge capture. `rx_byte_vld_o` equals the decoded valid flag in that cycle.
- R6: The receive flags are decoded as valid = control level at the rising edge, and error = rising-edge level XOR falling-edge level.
- R7: While valid and error are both decoded low, `rx_data_o` is zero and `rx_byte_vld_o` is low, whatever the data lines carry. At 1000 Mb/s with valid low and error high (carrier extension), the captured byte is passed through.
- R8: At 10/100 Mb/s, the rising-edge nibble of each period is taken. The first nibble of a pair is the low half. `rx_byte_vld_o` pulses with the assembled byte only when the second nibble arrives inside the same valid run. An unpaired nibble at the end of a run is dropped. Any cycle without valid zeroes `rx_data_o`.
- R9: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock (125, 25 or 2.5 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | 2 | Selected speed: 00 = 10, 01 = 100, 1x = 1000 Mb/s |
| link_speed_i | input | 2 | Speed currently reported for the link |
| tx_data_i | input | 8 | Transmit byte (10/100: low nibble only) |
| tx_en_i | input | 1 | Transmit enable |
| tx_er_i | input | 1 | Transmit error |
| rgmii_txc_o | output | 1 | Forwarded transmit clock |
| rgmii_txd_o | output | 4 | Transmit DDR data lines |
| rgmii_txctl_o | output | 1 | Transmit DDR control line |
| rgmii_rxd_i | input | 4 | Receive DDR data lines |
| rgmii_rxctl_i | input | 1 | Receive DDR control line |
| rx_data_o | output | 8 | Rebuilt receive byte |
| rx_dv_o | output | 1 | Decoded receive valid |
| rx_er_o | output | 1 | Decoded receive error |
| rx_byte_vld_o | output | 1 | Complete byte strobe |

## Verification
Transmit is driven with bytes whose two nibbles differ, so a swapped or duplicated half shows up on the lines. All four enable/error pairs are sent to tell the in-phase control level apart from the XOR level. Receive is fed all four control patterns with nonzero data. This separates a good frame, an errored frame, carrier extension and a true idle, where the data must be discarded. At 10/100 Mb/s, runs of even and odd length show whether the nibble pairing restarts with each run and whether an orphan nibble is dropped. A speed mismatch between `speed_i` and `link_speed_i` is held for several periods to show that the forwarded clock stays quiet.

// File: rtl/rgmii_pkg.sv
package rgmii_pkg;
  parameter int unsigned NIB_W_DEF = 4;

  typedef enum logic [1:0] {
    SPD_10M  = 2'b00,
    SPD_100M = 2'b01,
    SPD_1G   = 2'b10,
    SPD_1G_X = 2'b11
  } spd_e;

  function automatic logic is_gig(input spd_e s);
    return (s == SPD_1G) || (s == SPD_1G_X);
  endfunction
endpackage

// File: rtl/rgmii_tx_launch.sv
module rgmii_tx_launch #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gig_i,
  input  logic [BYTE_W-1:0] txd_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  output logic [NIB_W-1:0]  txd_o,
  output logic              txctl_o
);
  logic [NIB_W-1:0] lo_q, hi_q;
  logic             en_q, x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
      en_q <= 1'b0;
      x_q  <= 1'b0;
    end else begin
      lo_q <= txd_i[NIB_W-1:0];
      // 10/100: repeat the nibble in the second half
      hi_q <= gig_i ? txd_i[BYTE_W-1:NIB_W] : txd_i[NIB_W-1:0];
      en_q <= tx_en_i;
      x_q  <= tx_en_i ^ tx_er_i;
    end
  end

  // behavioural ODDR: first half while clock high, second half while low
  assign txd_o   = clk_i ? lo_q : hi_q;
  assign txctl_o = clk_i ? en_q : x_q;
endmodule

// File: rtl/rgmii_txc_gate.sv
module rgmii_txc_gate (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] speed_i,
  input  logic [1:0] link_speed_i,
  output logic       txc_o
);
  logic en_q;

  // updated while clock is low, so the gated clock never glitches
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= (speed_i == link_speed_i);
  end

  assign txc_o = clk_i & en_q;
endmodule

// File: rtl/rgmii_rx_capture.sv
module rgmii_rx_capture #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  rxd_i,
  input  logic              rxctl_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ctl_rise_o,
  output logic              ctl_fall_o
);
  logic [NIB_W-1:0] r_nib_q, f_nib_q;
  logic             r_ctl_q, f_ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_nib_q <= '0;
      r_ctl_q <= 1'b0;
    end else begin
      r_nib_q <= rxd_i;
      r_ctl_q <= rxctl_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_nib_q <= '0;
      f_ctl_q <= 1'b0;
    end else begin
      f_nib_q <= rxd_i;
      f_ctl_q <= rxctl_i;
    end
  end

  // realign the falling half back into the rising-edge domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o     <= '0;
      ctl_rise_o <= 1'b0;
      ctl_fall_o <= 1'b0;
    end else begin
      byte_o     <= {f_nib_q, r_nib_q};
      ctl_rise_o <= r_ctl_q;
      ctl_fall_o <= f_ctl_q;
    end
  end
endmodule

// File: rtl/rgmii_rx_decode.sv
module rgmii_rx_decode #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gig_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ctl_rise_i,
  input  logic              ctl_fall_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_dv_o,
  output logic              rx_er_o,
  output logic              rx_byte_vld_o
);
  logic             dv, er;
  logic             half_q;
  logic [NIB_W-1:0] lo_q;

  assign dv = ctl_rise_i;
  assign er = ctl_rise_i ^ ctl_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o     <= '0;
      rx_dv_o       <= 1'b0;
      rx_er_o       <= 1'b0;
      rx_byte_vld_o <= 1'b0;
      half_q        <= 1'b0;
      lo_q          <= '0;
    end else begin
      rx_dv_o <= dv;
      rx_er_o <= er;
      if (gig_i) begin
        half_q        <= 1'b0;
        rx_byte_vld_o <= dv;
        rx_data_o     <= (dv | er) ? byte_i : '0;
      end else if (!dv) begin
        half_q        <= 1'b0;
        rx_byte_vld_o <= 1'b0;
        rx_data_o     <= '0;
      end else if (!half_q) begin
        half_q        <= 1'b1;
        lo_q          <= byte_i[NIB_W-1:0];
        rx_byte_vld_o <= 1'b0;
      end else begin
        half_q        <= 1'b0;
        rx_byte_vld_o <= 1'b1;
        rx_data_o     <= {byte_i[NIB_W-1:0], lo_q};
      end
    end
  end
endmodule

// File: rtl/rgmii_ddr_adapter.sv
module rgmii_ddr_adapter
  import rgmii_pkg::*;
#(
  parameter int unsigned NIB_W = NIB_W_DEF,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        speed_i,
  input  logic [1:0]        link_speed_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  output logic              rgmii_txc_o,
  output logic [NIB_W-1:0]  rgmii_txd_o,
  output logic              rgmii_txctl_o,
  input  logic [NIB_W-1:0]  rgmii_rxd_i,
  input  logic              rgmii_rxctl_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_dv_o,
  output logic              rx_er_o,
  output logic              rx_byte_vld_o
);
  logic              gig;
  logic [BYTE_W-1:0] cap_byte;
  logic              cap_rise, cap_fall;

  assign gig = is_gig(spd_e'(speed_i));

  rgmii_txc_gate u_txc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_i     (speed_i),
    .link_speed_i(link_speed_i),
    .txc_o       (rgmii_txc_o)
  );

  rgmii_tx_launch #(.NIB_W(NIB_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gig_i  (gig),
    .txd_i  (tx_data_i),
    .tx_en_i(tx_en_i),
    .tx_er_i(tx_er_i),
    .txd_o  (rgmii_txd_o),
    .txctl_o(rgmii_txctl_o)
  );

  rgmii_rx_capture #(.NIB_W(NIB_W)) u_rxc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rxd_i     (rgmii_rxd_i),
    .rxctl_i   (rgmii_rxctl_i),
    .byte_o    (cap_byte),
    .ctl_rise_o(cap_rise),
    .ctl_fall_o(cap_fall)
  );

  rgmii_rx_decode #(.NIB_W(NIB_W)) u_rxd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gig_i        (gig),
    .byte_i       (cap_byte),
    .ctl_rise_i   (cap_rise),
    .ctl_fall_i   (cap_fall),
    .rx_data_o    (rx_data_o),
    .rx_dv_o      (rx_dv_o),
    .rx_er_o      (rx_er_o),
    .rx_byte_vld_o(rx_byte_vld_o)
  );
endmodule

// File: rtl/rgmii_ddr_adapter_chk.sv
module rgmii_ddr_adapter_chk #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        speed_i,
  input logic [1:0]        link_speed_i,
  input logic [BYTE_W-1:0] tx_data_i,
  input logic              tx_en_i,
  input logic              tx_er_i,
  input logic              rgmii_txc_o,
  input logic [NIB_W-1:0]  rgmii_txd_o,
  input logic              rgmii_txctl_o,
  input logic [BYTE_W-1:0] rx_data_o,
  input logic              rx_dv_o,
  input logic              rx_er_o,
  input logic              rx_byte_vld_o
);
  logic              s_v, s_gig, s_en, s_er;
  logic [BYTE_W-1:0] s_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_v <= 1'b0; s_gig <= 1'b0; s_en <= 1'b0; s_er <= 1'b0; s_d <= '0;
    end else begin
      s_v <= 1'b1; s_gig <= speed_i[1]; s_en <= tx_en_i; s_er <= tx_er_i; s_d <= tx_data_i;
    end
  end

  p_tx_lo_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    s_v |-> rgmii_txd_o == s_d[NIB_W-1:0]);
  p_tx_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_v && s_gig) |-> rgmii_txd_o == s_d[BYTE_W-1:NIB_W]);
  p_tx_ctl_hi_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    s_v |-> rgmii_txctl_o == s_en);
  p_tx_ctl_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_v |-> rgmii_txctl_o == (s_en ^ s_er));
  p_tx_dup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_v && !s_gig) |-> rgmii_txd_o == s_d[NIB_W-1:0]);
  p_txc_gate_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> rgmii_txc_o == ($past(speed_i) == $past(link_speed_i)));
  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_dv_o && !rx_er_o) |-> (rx_data_o == '0 && !rx_byte_vld_o));
  p_strobe_in_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_byte_vld_o |-> rx_dv_o);
endmodule

bind rgmii_ddr_adapter rgmii_ddr_adapter_chk #(.NIB_W(NIB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .speed_i      (speed_i),
  .link_speed_i (link_speed_i),
  .tx_data_i    (tx_data_i),
  .tx_en_i      (tx_en_i),
  .tx_er_i      (tx_er_i),
  .rgmii_txc_o  (rgmii_txc_o),
  .rgmii_txd_o  (rgmii_txd_o),
  .rgmii_txctl_o(rgmii_txctl_o),
  .rx_data_o    (rx_data_o),
  .rx_dv_o      (rx_dv_o),
  .rx_er_o      (rx_er_o),
  .rx_byte_vld_o(rx_byte_vld_o)
);

// File: tb/sim_rgmii_ddr_adapter.sv
`timescale 1ns/1ps
module sim_rgmii_ddr_adapter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] speed_i = 2'b10, link_speed_i = 2'b10;
  logic [7:0] tx_data_i = '0;
  logic       tx_en_i = 1'b0, tx_er_i = 1'b0;
  logic       rgmii_txc_o, rgmii_txctl_o;
  logic [3:0] rgmii_txd_o;
  logic [3:0] rgmii_rxd_i = '0;
  logic       rgmii_rxctl_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_dv_o, rx_er_o, rx_byte_vld_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rgmii_ddr_adapter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .speed_i(speed_i), .link_speed_i(link_speed_i),
    .tx_data_i(tx_data_i), .tx_en_i(tx_en_i), .tx_er_i(tx_er_i),
    .rgmii_txc_o(rgmii_txc_o), .rgmii_txd_o(rgmii_txd_o), .rgmii_txctl_o(rgmii_txctl_o),
    .rgmii_rxd_i(rgmii_rxd_i), .rgmii_rxctl_i(rgmii_rxctl_i),
    .rx_data_o(rx_data_o), .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .rx_byte_vld_o(rx_byte_vld_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- transmit ----------------
  // called in the low phase; checks both halves of the next period
  task automatic tx_vec(input logic [7:0] d, input logic en, input logic er);
    logic [3:0] hi_exp;
    tx_data_i = d; tx_en_i = en; tx_er_i = er;
    hi_exp = speed_i[1] ? d[7:4] : d[3:0];
    @(posedge clk); #2;
    chk(speed_i[1] ? "R1" : "R3", {rgmii_txd_o}, {d[3:0]});
    chk("R2", {rgmii_txctl_o}, {en});
    @(negedge clk); #2;
    chk(speed_i[1] ? "R1" : "R3", {rgmii_txd_o}, {hi_exp});
    chk("R2", {rgmii_txctl_o}, {en ^ er});
  endtask

  // ---------------- receive scoreboard ----------------
  typedef struct {
    int         due;
    logic [7:0] d;
    logic       dv, er, vld;
    string      tag;
  } exp_t;
  exp_t       sbq[$];
  logic       m_half = 0;
  logic [3:0] m_lo = '0;
  logic [7:0] m_data = '0;

  task automatic rx_vec(input logic [3:0] lo, input logic [3:0] hi, input logic cr, input logic cf);
    exp_t e;
    logic dv, er;
    rgmii_rxd_i = lo; rgmii_rxctl_i = cr;
    @(posedge clk); #1;
    e.due = cyc + 2;
    rgmii_rxd_i = speed_i[1] ? hi : lo; rgmii_rxctl_i = cf;
    dv = cr; er = cr ^ cf;
    if (speed_i[1]) begin
      m_half = 0; e.vld = dv; m_data = (dv | er) ? {hi, lo} : 8'h00;
      e.tag = (!dv && !er) ? "R7" : "R5/R6";
    end else if (!dv) begin
      m_half = 0; e.vld = 0; m_data = 8'h00; e.tag = "R7/R8";
    end else if (!m_half) begin
      m_half = 1; m_lo = lo; e.vld = 0; e.tag = "R8";
    end else begin
      m_half = 0; e.vld = 1; m_data = {lo, m_lo}; e.tag = "R8";
    end
    e.d = m_data; e.dv = dv; e.er = er;
    sbq.push_back(e);
    @(negedge clk); #1;
  endtask

  always begin
    @(posedge clk); #2;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.tag, {rx_data_o, rx_dv_o, rx_er_o, rx_byte_vld_o}, {e.d, e.dv, e.er, e.vld});
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    #18;
    // R9: everything low in reset
    chk("R9", {rgmii_txc_o, rgmii_txd_o, rgmii_txctl_o}, 0);
    chk("R9", {rx_data_o, rx_dv_o, rx_er_o, rx_byte_vld_o}, 0);
    #4;
    chk("R9", {rgmii_txc_o, rgmii_txd_o, rgmii_txctl_o}, 0);
    @(negedge clk); #1 rst_ni = 1'b1;

    // transmit, 1000 Mb/s
    tx_vec(8'hA5, 1, 0);
    tx_vec(8'h3C, 1, 1);
    tx_vec(8'h00, 0, 0);
    tx_vec(8'h0F, 0, 1);
    tx_vec(8'hE7, 1, 0);
    // transmit, 100 and 10 Mb/s: upper nibble must not appear
    speed_i = 2'b01; link_speed_i = 2'b01;
    tx_vec(8'h7E, 1, 0);
    tx_vec(8'hB2, 1, 1);
    speed_i = 2'b00; link_speed_i = 2'b00;
    tx_vec(8'hC9, 1, 0);
    tx_en_i = 0; tx_er_i = 0;

    // R4: clock gating on speed mismatch
    speed_i = 2'b10; link_speed_i = 2'b01;
    @(negedge clk); #1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2; chk("R4", {rgmii_txc_o}, 1'b0);
      @(negedge clk); #1;
    end
    link_speed_i = 2'b10;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2; chk("R4", {rgmii_txc_o}, 1'b1);
      @(negedge clk); #2; chk("R4", {rgmii_txc_o}, 1'b0);
    end
    #1;

    // receive, 1000 Mb/s
    rx_vec(4'h0, 4'h0, 0, 0);
    rx_vec(4'h5, 4'h5, 1, 1);
    rx_vec(4'h5, 4'hD, 1, 1);
    rx_vec(4'h1, 4'hA, 1, 1);
    rx_vec(4'h9, 4'h6, 1, 0);   // errored byte
    rx_vec(4'h2, 4'h4, 1, 1);
    rx_vec(4'hC, 4'h3, 0, 0);   // idle, data ignored
    rx_vec(4'hF, 4'h0, 0, 1);   // carrier extension
    rx_vec(4'h0, 4'h0, 0, 0);
    rx_vec(4'h0, 4'h0, 0, 0);
    rx_vec(4'h0, 4'h0, 0, 0);

    // receive, 100 Mb/s
    speed_i = 2'b01; link_speed_i = 2'b01;
    rx_vec(4'h8, 4'h8, 0, 0);
    rx_vec(4'h5, 4'h5, 1, 1);
    rx_vec(4'hA, 4'hA, 1, 1);   // byte A5
    rx_vec(4'h3, 4'h3, 1, 1);
    rx_vec(4'hC, 4'hC, 1, 1);   // byte C3
    rx_vec(4'hF, 4'hF, 0, 0);
    rx_vec(4'h1, 4'h1, 1, 1);
    rx_vec(4'h2, 4'h2, 1, 1);   // byte 21
    rx_vec(4'h7, 4'h7, 1, 1);   // orphan, dropped
    rx_vec(4'hE, 4'hE, 0, 0);
    rx_vec(4'h4, 4'h4, 1, 0);   // errored nibble
    rx_vec(4'h6, 4'h6, 1, 1);   // byte 64 with valid
    rx_vec(4'h9, 4'h9, 0, 1);
    rx_vec(4'h0, 4'h0, 0, 0);
    rx_vec(4'h0, 4'h0, 0, 0);
    rx_vec(4'h0, 4'h0, 0, 0);

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule